// File: doc/BRIEF.md
# Buffered Serial Master with Automatic Block Transfer

This block is a three-wire serial master (clock, data out, data in) that drives SPI mode 0 timing: the clock idles low, the master samples the input on each rising edge and changes its output on each falling edge. Bytes go out most significant bit first. The master has two ways of working. In the single-byte way, the host writes a byte into the data register. The block shifts it out and replaces it with the byte received. In the automatic way, the block walks a 32-entry internal buffer from index 0 up to a programmed last index. Each byte it receives is stored back into the slot it was sent from.

The host reaches the block through an 8-register port with reads that return one cycle after the address is presented, and through a separate port to the buffer. Command bits start or stop an automatic run. Both commands act only between bytes. A stopped run ends for good, and the index where it ended can be read back. A one-cycle interrupt marks the end of every single byte and of every automatic run. While the block is busy, its configuration is frozen, but the buffer stays open to the host.

Register map (address: contents): 0 control {bit0 enable, bit1 transmit enable}; 1 status {bit0 busy, bit1 ended-by-stop}; 2 divisor; 3 last index; 4 gap; 5 data; 6 command {bit0 start, bit1 stop}; 7 finish index. All other bits read as 0.

Top module: `spi_auto_master`

## Requirements
- R1: When the block is enabled and idle, a host write to the data register (address 5) sends that byte MSB first. Afterwards, address 5 reads back the byte received, and `irq` pulses for one cycle.
- R2: `sck` is low whenever no byte is shifting. Within a byte, consecutive rising edges of `sck` are exactly 2×(divisor+1) system clocks apart.
- R3: With transmit enable (control bit1) clear, `mosi` stays low for the whole byte. A dummy write to address 5 still runs a full receive, and the received byte is readable at address 5.
- R4: While status bit0 (busy) is 1, host writes to control, divisor, last index, gap and data change nothing, and they start no extra byte.
- R5: Writing command bit0 while enabled sends buffer slots 0 to last index, in rising order. The byte received in each slot's transfer overwrites that slot.
- R6: With gap N, the distance from the last rising `sck` edge of one buffered byte to the first rising edge of the next lies between 2×(N+1)×(divisor+1) and that value plus 8 system clocks.
- R7: Host writes to the buffer during an automatic run take effect. A slot written before it is fetched goes out with the new value.
- R8: A start command given during a single-byte transfer begins the automatic run only after that byte ends. A stop command given mid-byte ends the run after the current byte.
- R9: Both command bits read 0 after the interrupt that ends an automatic run. A stop command written when no automatic run is active is dropped.
- R10: At the end of an automatic run, address 7 holds the index of the last slot transferred. Status bit1 reads 1 only if the run ended on a stop command.
- R11: A start after a stopped run begins again at slot 0.
- R12: While enable (control bit0) is 0, last index, gap, finish index and status bit1 read 0. Buffer writes are dropped, buffer reads return 0, and start commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after the address |
| buf_we | input | 1 | Buffer write strobe |
| buf_addr | input | 5 | Buffer index |
| buf_wdata | input | 8 | Buffer write data |
| buf_rdata | output | 8 | Buffer read data, one cycle after the index |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The automatic run is driven with random buffer contents, random lengths up to 16 slots, divisors 0 to 3 and gaps 0 to 2. This separates errors in slot order, length, bit order and clock pacing, because the slave model replies with a byte pattern that differs for every byte. Directed runs cover four cases, each aimed at a different piece of logic: a stop placed mid-byte, a restart after a stop, a start queued behind a single byte, and a buffer write that lands while a run is going. Single bytes are tried with transmit on and off, with writes fired at a busy block, and against a disabled block. These show whether the gating of the configuration writes works apart from the shifting itself.

// File: rtl/spi_auto_pkg.sv
package spi_auto_pkg;
  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_STAT = 3'd1,
    RA_DIV  = 3'd2,
    RA_LAST = 3'd3,
    RA_GAP  = 3'd4,
    RA_DATA = 3'd5,
    RA_CMD  = 3'd6,
    RA_ACNT = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {CS_IDLE, CS_SHIFT, CS_GAP} core_st_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_LOAD, SQ_RUN} seq_st_e;
endpackage

// File: rtl/spi_buf_ram.sv
module spi_buf_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  // host port is ordered last so it wins a same-slot collision
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core import spi_auto_pkg::*; #(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tx_en,
  input  logic [7:0]       tx_data,
  input  logic [DIV_W-1:0] div,
  input  logic [GAP_W-1:0] gap,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_data
);
  localparam logic [GAP_W:0] GONE = {{GAP_W{1'b0}}, 1'b1};

  core_st_e         st;
  logic [DIV_W-1:0] hcnt;
  logic             ph;
  logic [2:0]       bitn;
  logic [7:0]       tx_sh;
  logic             txe;
  logic [GAP_W:0]   gcnt;
  logic             tick;

  assign tick    = (hcnt == '0);
  assign busy    = (st != CS_IDLE);
  assign mosi    = txe & tx_sh[7];
  assign done    = tick && ((st == CS_SHIFT && ph && bitn == 3'd7 && gcnt == '0) ||
                            (st == CS_GAP && gcnt == GONE));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= CS_IDLE; hcnt <= '0; ph <= 1'b0; bitn <= '0; tx_sh <= '0;
      txe <= 1'b0; gcnt <= '0; sck <= 1'b0; rx_data <= '0;
    end else begin
      case (st)
        CS_IDLE: if (start) begin
          tx_sh <= tx_data; txe <= tx_en; gcnt <= {gap, 1'b0};
          hcnt <= div; ph <= 1'b0; bitn <= '0; st <= CS_SHIFT;
        end
        CS_SHIFT: if (tick) begin
          hcnt <= div;
          if (!ph) begin
            sck <= 1'b1; ph <= 1'b1;
            rx_data <= {rx_data[6:0], miso};
          end else begin
            sck <= 1'b0; ph <= 1'b0;
            if (bitn == 3'd7) st <= (gcnt == '0) ? CS_IDLE : CS_GAP;
            else begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              bitn  <= bitn + 3'd1;
            end
          end
        end else hcnt <= hcnt - 1'b1;
        default: if (tick) begin
          hcnt <= div; gcnt <= gcnt - 1'b1;
          if (gcnt == GONE) st <= CS_IDLE;
        end else hcnt <= hcnt - 1'b1;
      endcase
    end
  end

  a_r2_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
    (st != CS_SHIFT) |-> !sck);
  a_r8_start_only_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> (st == CS_IDLE));
endmodule

// File: rtl/spi_auto_seq.sv
module spi_auto_seq import spi_auto_pkg::*; #(
  parameter int AW    = 5,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             stop_req,
  input  logic [AW-1:0]    last,
  input  logic [GAP_W-1:0] gap,
  input  logic             core_done,
  input  logic [7:0]       core_rx,
  output logic             active,
  output logic             load,
  output logic [AW-1:0]    ram_addr,
  output logic             ram_we,
  output logic [7:0]       ram_wdata,
  output logic [GAP_W-1:0] core_gap,
  output logic             ended,
  output logic [AW-1:0]    last_idx,
  output logic             by_stop
);
  seq_st_e       st;
  logic [AW-1:0] idx;

  assign active    = (st != SQ_IDLE);
  assign load      = (st == SQ_LOAD);
  assign ram_addr  = idx;
  assign ram_we    = (st == SQ_RUN) && core_done;
  assign ram_wdata = core_rx;
  assign core_gap  = (idx == last) ? '0 : gap;
  assign ended     = ram_we && (stop_req || idx == last);
  assign last_idx  = idx;
  assign by_stop   = stop_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE; idx <= '0;
    end else begin
      case (st)
        SQ_IDLE:  if (go) begin idx <= '0; st <= SQ_FETCH; end
        SQ_FETCH: st <= SQ_LOAD;
        SQ_LOAD:  st <= SQ_RUN;
        default:  if (ended) st <= SQ_IDLE;
                  else if (core_done) begin idx <= idx + 1'b1; st <= SQ_FETCH; end
      endcase
    end
  end

  a_r5_writeback_in_range: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (idx <= last));
  a_r11_run_starts_at_zero: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_IDLE && go) |=> (idx == '0));
endmodule

// File: rtl/spi_auto_master.sv
module spi_auto_master import spi_auto_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int DIV_W = 8,
  parameter int GAP_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  output logic [7:0]    buf_rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic          irq
);
  reg_addr_e        wsel;
  logic             ctrl_en, tx_en_q, stopped_q, cmd_start, cmd_stop, en_rd;
  logic [DIV_W-1:0] div_q;
  logic [AW-1:0]    last_q, acnt_q;
  logic [GAP_W-1:0] gap_q;
  logic [7:0]       data_q, host_rd, seq_rd, core_rx, seq_wdata;
  logic             busy, wr_ok, shift_wr, seq_go;
  logic             core_busy, core_done, core_start;
  logic             seq_active, seq_load, seq_we, seq_end, seq_by_stop;
  logic [AW-1:0]    seq_addr, seq_last;
  logic [GAP_W-1:0] seq_gap;

  assign wsel       = reg_addr_e'(reg_addr);
  assign busy       = core_busy | seq_active;
  assign wr_ok      = reg_we && !busy;
  assign shift_wr   = wr_ok && wsel == RA_DATA && ctrl_en;
  assign seq_go     = cmd_start && ctrl_en && !busy && !shift_wr;
  assign core_start = shift_wr | seq_load;
  assign buf_rdata  = en_rd ? host_rd : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0; tx_en_q <= 1'b0; div_q <= '0; last_q <= '0; gap_q <= '0;
      data_q <= '0; cmd_start <= 1'b0; cmd_stop <= 1'b0; stopped_q <= 1'b0;
      acnt_q <= '0; irq <= 1'b0; en_rd <= 1'b0;
    end else begin
      en_rd <= ctrl_en;
      irq   <= (core_done && !seq_active) || seq_end;
      if (wr_ok && wsel == RA_CTRL) begin
        ctrl_en <= reg_wdata[0]; tx_en_q <= reg_wdata[1];
      end
      if (wr_ok && wsel == RA_DIV)  div_q  <= reg_wdata[DIV_W-1:0];
      if (wr_ok && wsel == RA_LAST) last_q <= reg_wdata[AW-1:0];
      if (wr_ok && wsel == RA_GAP)  gap_q  <= reg_wdata[GAP_W-1:0];
      if (shift_wr) data_q <= reg_wdata;
      if (core_done && !seq_active) data_q <= core_rx;
      if (reg_we && wsel == RA_CMD && ctrl_en) begin
        if (reg_wdata[0]) cmd_start <= 1'b1;
        if (reg_wdata[1] && seq_active) cmd_stop <= 1'b1;
      end
      if (seq_end) begin
        cmd_start <= 1'b0; cmd_stop <= 1'b0;
        acnt_q <= seq_last; stopped_q <= seq_by_stop;
      end
      if (!ctrl_en) begin
        last_q <= '0; gap_q <= '0; acnt_q <= '0; stopped_q <= 1'b0;
        cmd_start <= 1'b0; cmd_stop <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (wsel)
        RA_CTRL: reg_rdata <= {6'd0, tx_en_q, ctrl_en};
        RA_STAT: reg_rdata <= {6'd0, stopped_q, busy};
        RA_DIV:  reg_rdata <= 8'(div_q);
        RA_LAST: reg_rdata <= 8'(last_q);
        RA_GAP:  reg_rdata <= 8'(gap_q);
        RA_DATA: reg_rdata <= data_q;
        RA_CMD:  reg_rdata <= {6'd0, cmd_stop, cmd_start};
        default: reg_rdata <= 8'(acnt_q);
      endcase
    end
  end

  spi_buf_ram #(.DEPTH(DEPTH), .DW(8)) u_ram (
    .clk(clk),
    .a_we(buf_we && ctrl_en), .a_addr(buf_addr), .a_wdata(buf_wdata), .a_rdata(host_rd),
    .b_we(seq_we), .b_addr(seq_addr), .b_wdata(seq_wdata), .b_rdata(seq_rd)
  );

  spi_auto_seq #(.AW(AW), .GAP_W(GAP_W)) u_seq (
    .clk(clk), .rst(rst), .go(seq_go), .stop_req(cmd_stop), .last(last_q), .gap(gap_q),
    .core_done(core_done), .core_rx(core_rx), .active(seq_active), .load(seq_load),
    .ram_addr(seq_addr), .ram_we(seq_we), .ram_wdata(seq_wdata), .core_gap(seq_gap),
    .ended(seq_end), .last_idx(seq_last), .by_stop(seq_by_stop)
  );

  spi_shift_core #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u_core (
    .clk(clk), .rst(rst), .start(core_start), .tx_en(tx_en_q),
    .tx_data(seq_load ? seq_rd : reg_wdata), .div(div_q),
    .gap(seq_load ? seq_gap : '0), .miso(miso), .sck(sck), .mosi(mosi),
    .busy(core_busy), .done(core_done), .rx_data(core_rx)
  );

  a_r4_config_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(div_q) && $stable(last_q) && $stable(gap_q) &&
              $stable(ctrl_en) && $stable(tx_en_q)));
  a_r9_cmd_self_clear: assert property (@(posedge clk) disable iff (rst)
    seq_end |=> (!cmd_start && !cmd_stop));
  a_r12_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> (last_q == '0 && gap_q == '0 && acnt_q == '0 && !stopped_q));
  a_r8_one_launch: assert property (@(posedge clk) disable iff (rst)
    !(shift_wr && seq_load));
endmodule

// File: tb/spi_auto_master_test.sv
module spi_auto_master_test;
  logic       clk = 1'b0, rst = 1'b1;
  logic       reg_we = 1'b0, buf_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, buf_wdata = '0;
  logic [4:0] buf_addr = '0;
  logic [7:0] reg_rdata, buf_rdata;
  logic       sck, mosi, irq;
  logic       miso;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_auto_master uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
  );

  // slave model: captures mosi, replies with a distinct byte per transfer
  function automatic logic [7:0] resp(int k);
    return 8'((k * 29 + 7) ^ 90);
  endfunction

  int cyc = 0, sbit = 0, ncap = 0, prev_rise = 0, h_exp = 1, sp_err = 0;
  logic [7:0] slv, sin;
  logic [7:0] cap [256];
  int first_rise [256];
  int last_rise  [256];
  logic sck_prev = 1'b0;
  logic [7:0] shadow [32];

  initial slv = resp(0);
  assign miso = slv[7];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sck && !sck_prev) begin
      if (sbit == 0) first_rise[ncap % 256] = cyc;
      else if (cyc - prev_rise != 2 * h_exp) sp_err = sp_err + 1;
      prev_rise = cyc;
      sin = {sin[6:0], mosi};
      sbit = sbit + 1;
      if (sbit == 8) begin
        cap[ncap % 256] = sin;
        last_rise[ncap % 256] = cyc;
        ncap = ncap + 1;
      end
    end
    if (!sck && sck_prev) begin
      if (sbit == 8) begin sbit = 0; slv = resp(ncap); end
      else slv = {slv[6:0], 1'b0};
    end
    sck_prev = sck;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(int a, int d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(int a, output logic [7:0] d);
    @(negedge clk); reg_addr = 3'(a);
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic buf_wr(int a, int d);
    @(negedge clk); buf_we = 1'b1; buf_addr = 5'(a); buf_wdata = 8'(d);
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic buf_rd(int a, output logic [7:0] d);
    @(negedge clk); buf_addr = 5'(a);
    @(negedge clk); d = buf_rdata;
  endtask

  task automatic wait_irq(string req);
    int n = 0;
    @(negedge clk);
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    chk(irq, {req, " irq"}, 0, 1);
  endtask

  task automatic set_div(int d);
    reg_wr(2, d); h_exp = d + 1;
  endtask

  // checks one finished automatic run from global byte g0 over slots 0..last
  task automatic check_run(int g0, int last, int gap, string req);
    logic [7:0] v;
    for (int i = 0; i <= last; i++) begin
      chk(cap[(g0 + i) % 256] == shadow[i], {req, " sent"}, cap[(g0 + i) % 256], shadow[i]);
      shadow[i] = resp(g0 + i);
      buf_rd(i, v);
      chk(v == shadow[i], "R5 slot writeback", v, shadow[i]);
    end
    for (int i = 0; i < last; i++) begin
      int d = first_rise[(g0 + i + 1) % 256] - last_rise[(g0 + i) % 256];
      int lo = 2 * (gap + 1) * h_exp;
      chk(d >= lo && d <= lo + 8, "R6 gap", d, lo);
    end
    chk(ncap == g0 + last + 1, {req, " count"}, ncap, g0 + last + 1);
    chk(sp_err == 0, "R2 period", sp_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int g0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    for (int a = 0; a < 8; a++) begin
      reg_rd(a, v);
      chk(v == 8'h00, "R12 reset regs", v, 0);
    end
    chk(sck == 1'b0, "R2 idle sck", sck, 0);
    chk(irq == 1'b0, "R1 idle irq", irq, 0);

    // single byte, transmit on
    reg_wr(0, 3); set_div(1);
    g0 = ncap;
    reg_wr(5, 8'hA5);
    wait_irq("R1");
    chk(cap[g0] == 8'hA5, "R1 mosi byte", cap[g0], 8'hA5);
    reg_rd(5, v);
    chk(v == resp(g0), "R1 rx byte", v, resp(g0));
    chk(sp_err == 0, "R2 period", sp_err, 0);
    chk(sck == 1'b0, "R2 idle sck after", sck, 0);

    // receive only
    reg_wr(0, 1); set_div(0);
    g0 = ncap;
    reg_wr(5, 8'hFF);
    wait_irq("R3");
    chk(cap[g0] == 8'h00, "R3 mosi low", cap[g0], 0);
    reg_rd(5, v);
    chk(v == resp(g0), "R3 rx byte", v, resp(g0));

    // writes while busy
    reg_wr(0, 3); set_div(2); reg_wr(3, 4); reg_wr(4, 1);
    g0 = ncap;
    reg_wr(5, 8'h3C);
    reg_rd(1, v);
    chk(v[0] == 1'b1, "R4 busy flag", v, 1);
    reg_wr(2, 7); reg_wr(3, 9); reg_wr(4, 5); reg_wr(5, 8'h11); reg_wr(0, 0);
    wait_irq("R4");
    repeat (40) @(negedge clk);
    chk(ncap == g0 + 1, "R4 no extra byte", ncap, g0 + 1);
    chk(cap[g0] == 8'h3C, "R4 byte kept", cap[g0], 8'h3C);
    reg_rd(2, v); chk(v == 8'd2, "R4 div", v, 2);
    reg_rd(3, v); chk(v == 8'd4, "R4 last", v, 4);
    reg_rd(4, v); chk(v == 8'd1, "R4 gap", v, 1);
    reg_rd(0, v); chk(v == 8'd3, "R4 ctrl", v, 3);
    reg_rd(5, v); chk(v == resp(g0), "R4 data", v, resp(g0));

    // fill buffer
    for (int i = 0; i < 32; i++) begin
      shadow[i] = 8'($urandom);
      buf_wr(i, shadow[i]);
    end

    // random automatic runs
    for (int it = 0; it < 6; it++) begin
      int d = $urandom_range(0, 3);
      int l = $urandom_range(0, 15);
      int gp = $urandom_range(0, 2);
      for (int i = 0; i <= l; i++) begin
        shadow[i] = 8'($urandom);
        buf_wr(i, shadow[i]);
      end
      set_div(d); reg_wr(3, l); reg_wr(4, gp);
      g0 = ncap;
      reg_wr(6, 1);
      wait_irq("R5");
      check_run(g0, l, gp, "R5");
      reg_rd(7, v); chk(v == 8'(l), "R10 finish index", v, l);
      reg_rd(1, v); chk(v == 8'h00, "R10 status", v, 0);
      reg_rd(6, v); chk(v == 8'h00, "R9 cmd cleared", v, 0);
    end

    // buffer write during a run
    set_div(3); reg_wr(3, 5); reg_wr(4, 0);
    g0 = ncap;
    reg_wr(6, 1);
    while (ncap < g0 + 1) @(negedge clk);
    buf_wr(5, 8'hE7); shadow[5] = 8'hE7;
    wait_irq("R7");
    chk(cap[(g0 + 5) % 256] == 8'hE7, "R7 late write sent", cap[(g0 + 5) % 256], 8'hE7);
    check_run(g0, 5, 0, "R7");

    // stop mid-byte
    set_div(2); reg_wr(3, 9);
    g0 = ncap;
    reg_wr(6, 1);
    while (!(ncap == g0 + 2 && sbit >= 3)) @(negedge clk);
    reg_wr(6, 2);
    wait_irq("R8");
    repeat (60) @(negedge clk);
    chk(ncap == g0 + 3, "R8 stop after byte", ncap, g0 + 3);
    reg_rd(7, v); chk(v == 8'd2, "R10 stop index", v, 2);
    reg_rd(1, v); chk(v == 8'h02, "R10 stopped flag", v, 2);
    reg_rd(6, v); chk(v == 8'h00, "R9 cmd cleared stop", v, 0);
    for (int i = 0; i < 3; i++) shadow[i] = resp(g0 + i);
    for (int i = 3; i <= 9; i++) begin
      buf_rd(i, v); chk(v == shadow[i], "R8 untouched slot", v, shadow[i]);
    end

    // restart after stop
    g0 = ncap;
    reg_wr(6, 1);
    wait_irq("R11");
    chk(cap[g0 % 256] == shadow[0], "R11 restart slot0", cap[g0 % 256], shadow[0]);
    check_run(g0, 9, 0, "R11");
    reg_rd(1, v); chk(v == 8'h00, "R10 normal end flag", v, 0);

    // start queued behind a single byte
    reg_wr(3, 2);
    g0 = ncap;
    reg_wr(5, 8'h5A);
    reg_wr(6, 1);
    wait_irq("R8 single");
    chk(ncap == g0 + 1, "R8 auto waits", ncap, g0 + 1);
    reg_rd(6, v); chk(v == 8'h01, "R9 start kept", v, 1);
    wait_irq("R8 auto");
    chk(cap[g0 % 256] == 8'h5A, "R8 single byte", cap[g0 % 256], 8'h5A);
    check_run(g0 + 1, 2, 0, "R8");

    // stop while idle is dropped
    reg_wr(6, 2);
    reg_rd(6, v); chk(v == 8'h00, "R9 idle stop dropped", v, 0);
    g0 = ncap;
    reg_wr(6, 1);
    wait_irq("R9");
    check_run(g0, 2, 0, "R9");

    // disable
    reg_wr(0, 0);
    reg_rd(3, v); chk(v == 8'h00, "R12 last cleared", v, 0);
    reg_rd(4, v); chk(v == 8'h00, "R12 gap cleared", v, 0);
    reg_rd(7, v); chk(v == 8'h00, "R12 index cleared", v, 0);
    reg_rd(1, v); chk(v == 8'h00, "R12 status cleared", v, 0);
    buf_wr(0, 8'h99);
    buf_rd(0, v); chk(v == 8'h00, "R12 buffer blocked", v, 0);
    reg_wr(6, 1);
    reg_rd(6, v); chk(v == 8'h00, "R12 start ignored", v, 0);
    repeat (20) @(negedge clk);
    chk(sck == 1'b0, "R12 no activity", sck, 0);
    reg_wr(0, 3);
    buf_rd(0, v); chk(v == shadow[0], "R12 write dropped", v, shadow[0]);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule